// File: doc/BRIEF.md
# Sticky Fault Status Register

This block holds an 8-bit status word that remembers which monitored supply sources have failed. After power-on every bit is zero, so nothing is recorded. The host arms the word by writing the value 09h, which sets the two monitored positions, bit 0 and bit 3, to 1. From then on, any failure of a monitored source forces its bit to 0. The bit stays at 0 after the source recovers, until the host writes a 1 back.

A host that sees a system reset reads the word to find out which source caused it. It then writes the pattern again to re-arm the flags. Source 0 maps to bit 0 and source 1 maps to bit 3. The other six bits are reserved: they store whatever the host writes and nothing else changes them. Reading has no side effects. The read data is the register value captured on the previous clock edge.

Top module: `sticky_fault_reg`

## Requirements
- R1: A synchronous active-high `rst` forces all 8 bits to 0 on the next rising edge. Reset has priority over a write that arrives in the same cycle.
- R2: When `wr_en` is 1 and no failure is active, `rd_data` equals `wr_data` after the next rising edge.
- R3: Writing 09h arms the register, so that bit 0 and bit 3 read as 1.
- R4: When `src_fail[0]` is 1 at a rising edge, bit 0 reads 0 after that edge. When `src_fail[1]` is 1 at a rising edge, bit 3 reads 0 after that edge.
- R5: A bit cleared by a failure stays 0 after the failure input returns to 0, as long as no write occurs.
- R6: When a write of 1 to a monitored bit coincides with that bit's failure input, the failure wins and the bit reads 0.
- R7: Failure inputs never change the reserved bits 1, 2, 4, 5, 6 and 7. Those bits change only through a write or a reset.
- R8: A host write of 0 to any bit, monitored or reserved, takes effect on the next edge.
- R9: With no write and no active failure, the register value does not change from one edge to the next.
- R10: A failure on a monitored bit that is already 0 leaves it at 0. An unarmed register records nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Host write strobe for the current cycle |
| wr_data | input | 8 | Value the host writes |
| src_fail | input | 2 | Per-source failure indications: index 0 maps to bit 0, index 1 maps to bit 3 |
| rd_data | output | 8 | Current register value |

## Verification
The stimulus runs through several patterns, and each one separates a different rule:
- **Arm pattern, then each failure on its own.** Shows that each source clears only its own bit.
- **Failure removed with no write.** Shows the sticky behaviour, as opposed to a bit that simply follows its input.
- **All-ones write during a failure, and a mixed write such as A5h.** Show failure priority and the behaviour of the reserved bits.
- **Zero write, then failures on the cleared register.** Shows that a host write of 0 acts directly and that an unarmed register records nothing.
- **Reset asserted during a write.** Checks reset priority.

// File: rtl/fault_reg_pkg.sv
package fault_reg_pkg;
    localparam int unsigned REG_W   = 8;
    localparam int unsigned NUM_SRC = 2;
    localparam logic [REG_W-1:0] ARM_VALUE = 8'h09;

    typedef logic [REG_W-1:0] reg_word_t;

    typedef struct packed {
        logic      en;
        reg_word_t data;
    } host_wr_t;

    // Bit position that records the failure of a given source.
    function automatic int unsigned src_pos(input int unsigned s);
        case (s)
            0:       return 0;
            1:       return 3;
            default: return 0;
        endcase
    endfunction

    // Mask of the bit positions that failure inputs can clear.
    function automatic reg_word_t monitored_mask();
        reg_word_t m;
        m = '0;
        for (int unsigned s = 0; s < NUM_SRC; s++) begin
            m[src_pos(s)] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/fault_src_map.sv
module fault_src_map
    import fault_reg_pkg::*;
(
    input  logic [NUM_SRC-1:0] src_fail,
    output reg_word_t          clr_mask
);
    reg_word_t part [NUM_SRC];

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        always_comb begin
            part[s] = '0;
            part[s][src_pos(s)] = src_fail[s];
        end
    end

    always_comb begin
        clr_mask = '0;
        for (int unsigned s = 0; s < NUM_SRC; s++) begin
            clr_mask = clr_mask | part[s];
        end
    end

    // R7
    always_comb begin
        map_reserved_chk: assert ((clr_mask & ~monitored_mask()) == '0);
    end
endmodule

// File: rtl/fault_bit_cell.sv
module fault_bit_cell (
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  logic d,
    input  logic clr,
    output logic q
);
    logic q_r;

    always_ff @(posedge clk) begin
        if (rst)       q_r <= 1'b0;
        else if (clr)  q_r <= 1'b0;
        else if (we)   q_r <= d;
    end

    assign q = q_r;

    // R4
    clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !q);
    // R2
    load_chk: assert property (@(posedge clk) disable iff (rst)
        (we && !clr) |=> (q == $past(d)));
    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!we && !clr) |=> $stable(q));
endmodule

// File: rtl/sticky_fault_reg.sv
module sticky_fault_reg
    import fault_reg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    input  logic [NUM_SRC-1:0] src_fail,
    output logic [REG_W-1:0]   rd_data
);
    localparam reg_word_t RSV_MASK = ~monitored_mask();

    host_wr_t  host;
    reg_word_t clr_mask;
    reg_word_t word_q;

    assign host.en   = wr_en;
    assign host.data = wr_data;

    fault_src_map u_map (
        .src_fail (src_fail),
        .clr_mask (clr_mask)
    );

    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        fault_bit_cell u_cell (
            .clk (clk),
            .rst (rst),
            .we  (host.en),
            .d   (host.data[b]),
            .clr (clr_mask[b]),
            .q   (word_q[b])
        );
    end

    assign rd_data = word_q;

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (rd_data == '0));
    // R7
    reserved_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ((rd_data & RSV_MASK) == ($past(rd_data) & RSV_MASK)));
    // R10
    no_set_by_fail_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ((rd_data & ~$past(rd_data)) == '0));
endmodule

// File: tb/sticky_fault_reg_bench.sv
`timescale 1ns/1ps
module sticky_fault_reg_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] src_fail = '0;
    logic [7:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sticky_fault_reg u_sticky_fault_reg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .src_fail (src_fail),
        .rd_data  (rd_data)
    );

    // {wr_en, wr_data, src_fail, expected rd_data}
    localparam int NV = 12;
    localparam logic [18:0] VEC [NV] = '{
        {1'b1, 8'h09, 2'b00, 8'h09},   // R3 arm
        {1'b0, 8'h00, 2'b01, 8'h08},   // R4 source 0 -> bit 0
        {1'b0, 8'h00, 2'b00, 8'h08},   // R5 sticky after recovery
        {1'b0, 8'h00, 2'b10, 8'h00},   // R4 source 1 -> bit 3
        {1'b1, 8'h09, 2'b00, 8'h09},   // R3 re-arm
        {1'b1, 8'hFF, 2'b10, 8'hF7},   // R6 failure beats write
        {1'b0, 8'h00, 2'b11, 8'hF6},   // R7 reserved untouched
        {1'b1, 8'hA5, 2'b00, 8'hA5},   // R2 plain load
        {1'b1, 8'h00, 2'b00, 8'h00},   // R8 write zero
        {1'b0, 8'h00, 2'b11, 8'h00},   // R10 unarmed records nothing
        {1'b0, 8'h00, 2'b00, 8'h00},   // R9 hold
        {1'b1, 8'h6B, 2'b01, 8'h6A}    // R6 failure on bit 0 during write
    };

    task automatic check(input string req, input logic [7:0] exp);
        n_chk++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
        end
    endtask

    task automatic step(input logic we, input logic [7:0] d, input logic [1:0] f);
        @(negedge clk);
        wr_en = we;
        wr_data = d;
        src_fail = f;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 8'h00);
        rst = 1'b0;
        @(negedge clk);
        check("R9", 8'h00);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][18], VEC[i][17:10], VEC[i][9:8]);
            check($sformatf("vec%0d R2..R10", i), VEC[i][7:0]);
        end

        // R7: reserved bits hold through failures with no write
        step(1'b1, 8'hF6, 2'b00);
        check("R2", 8'hF6);
        step(1'b0, 8'h00, 2'b11);
        check("R7", 8'hF6);

        // R5: sticky over several idle cycles
        step(1'b1, 8'h09, 2'b00);
        step(1'b0, 8'h00, 2'b10);
        step(1'b0, 8'h00, 2'b00);
        step(1'b0, 8'h00, 2'b00);
        check("R5", 8'h01);

        // R1: reset wins over a simultaneous write
        @(negedge clk);
        rst = 1'b1;
        wr_en = 1'b1;
        wr_data = 8'hFF;
        src_fail = 2'b00;
        @(negedge clk);
        check("R1", 8'h00);
        rst = 1'b0;
        wr_en = 1'b0;
        @(negedge clk);
        check("R1", 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule